// File: doc/BRIEF.md
# Fetch Group Extractor

This block turns one buffered 64-byte instruction cache line into a group of up to `FW` 32-bit instructions for the decode queue. It is given the current fetch PC and a pulse saying that the line is ready. One cycle later it presents the group. Each slot carries the instruction word, its PC, its predicted next PC, a sequence number and a fault flag. The block also reports how many slots are valid, pulses a write strobe for the decode queue, and returns the updated thread PC together with the PC that follows it.

For every word of the line, the block also receives a control-flow flag, a taken prediction and a predicted target. A separate flag marks quiesce instructions. A group ends at the first of these events: the end of the line, the fetch width being reached, a predicted-taken control instruction, or a quiesce instruction. The instruction that ends the group is always emitted.

A translation fault replaces the group with a single no-op slot that has its fault flag set. A quiesce or a fault parks the thread in a pending state. While it is pending, fetch pulses are ignored until a wake pulse arrives. The block also drives the line-aligned request address for the instruction cache as combinational logic from the fetch PC.

Top module: `fx_extractor`

## Requirements
- R1: `req_addr_o` equals `fetch_pc_i` with its low 6 bits cleared, in the same cycle.
- R2: Extraction begins at word index `fetch_pc_i[5:2]`. Slot 0 PC is `fetch_pc_i` with bits [1:0] cleared. Word `w` of the line is `line_i[32*w+31:32*w]`, which is the little-endian reading of bytes 4w..4w+3.
- R3: When an instruction's control flag is 0, or its taken bit is 0, its next PC is its PC plus 4. The taken bit and target of a word whose control flag is 0 are ignored. Slot k+1 has the PC equal to the next PC of slot k.
- R4: Without a stopping instruction, the slot count is min(FW, 16 - start word index).
- R5: A word with both its control flag and its taken bit set is emitted as the last slot of the group, and its next PC is its target.
- R6: A word with its quiesce flag set is emitted and counted as the last slot. The block then raises `quiesce_pend_o`.
- R7: Sequence numbers come from one counter that is 0 after reset. Each emitted slot takes the next value, so slots within a group are consecutive.
- R8: After a group, `thread_pc_o` is the next PC of the last slot, and `thread_npc_o` is that value plus 4.
- R9: When `xlate_fault_i` is set on a fetch, the group is one slot with word 0, fault flag 1, PC equal to the aligned fetch PC, and next PC equal to that PC plus 4. `trap_pend_o` is raised and the thread PC becomes the aligned fetch PC.
- R10: While `quiesce_pend_o` or `trap_pend_o` is high, a fetch pulse produces no slots and leaves the thread PC and the sequence counter unchanged. A wake pulse clears both pending flags.
- R11: Results appear on the clock edge after the edge that samples `fetch_go_i`. `dq_wr_o` is high exactly when the slot count is nonzero. The count never exceeds FW, and the fields of slots at or above the count read 0.
- R12: During and after reset, all outputs other than `req_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| fetch_go_i | input | 1 | line buffer holds the line for the current PC |
| fetch_pc_i | input | 32 | current fetch PC |
| line_i | input | 512 | cache line, word w at bits 32w+31:32w |
| ctl_i | input | 16 | per-word control-flow flag |
| taken_i | input | 16 | per-word predicted-taken bit |
| target_i | input | 512 | per-word predicted target, word w at bits 32w+31:32w |
| quiesce_i | input | 16 | per-word quiesce flag |
| xlate_fault_i | input | 1 | translation fault for this fetch |
| wake_i | input | 1 | leaves a pending state |
| req_addr_o | output | 32 | line-aligned request address |
| dq_wr_o | output | 1 | decode-queue write strobe |
| slot_count_o | output | 3 | number of valid slots |
| slot_inst_o | output | 128 | instruction words, slot k at bits 32k+31:32k |
| slot_pc_o | output | 128 | slot PCs |
| slot_npc_o | output | 128 | slot predicted next PCs |
| slot_seq_o | output | 64 | slot sequence numbers, 16 bits each |
| slot_fault_o | output | 4 | per-slot fault flag |
| thread_pc_o | output | 32 | updated thread PC |
| thread_npc_o | output | 32 | updated thread next PC |
| quiesce_pend_o | output | 1 | thread waits after a quiesce |
| trap_pend_o | output | 1 | thread waits after a fault |

## Verification
The bench tries every one of the 64 byte offsets within a line against the same set of per-word patterns:
- A plain line whose taken bits are set while its control flags are clear. This separates width-limited groups from line-end-limited groups, and shows that predictions on non-control words are ignored.
- A line where every word is a not-taken control instruction.
- A taken branch placed at each of the 16 word positions. This shows whether the group stops exactly at the branch and redirects to its target.
- A quiesce placed at each position.
- A faulting fetch.

After each quiesce or fault, a further fetch pulse shows that a pending thread emits nothing and consumes no sequence numbers. A wake pulse then clears the pending state.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        TH_RUN     = 2'd0,
        TH_QUIESCE = 2'd1,
        TH_TRAP    = 2'd2
    } th_state_e;

    // clear the offset bits below a power-of-two boundary
    function automatic logic [31:0] align_down(input logic [31:0] a, input int unsigned bytes);
        return a & ~(32'(bytes) - 32'd1);
    endfunction

endpackage

// File: rtl/fx_slot_walk.sv
module fx_slot_walk
    import fx_pkg::*;
#(
    parameter int FW    = 4,
    parameter int WORDS = 16,
    parameter int PC_W  = 32,
    localparam int IW    = $clog2(WORDS),
    localparam int CNT_W = $clog2(FW + 1)
) (
    input  logic [PC_W-1:0]       pc_i,
    input  logic [WORDS*32-1:0]   line_i,
    input  logic [WORDS-1:0]      ctl_i,
    input  logic [WORDS-1:0]      taken_i,
    input  logic [WORDS*PC_W-1:0] target_i,
    input  logic [WORDS-1:0]      quiesce_i,
    output logic [FW-1:0]         valid_o,
    output logic [31:0]           inst_o [FW],
    output logic [PC_W-1:0]       pc_o   [FW],
    output logic [PC_W-1:0]       npc_o  [FW],
    output logic [CNT_W-1:0]      count_o,
    output logic [PC_W-1:0]       last_npc_o,
    output logic                  quiesce_hit_o
);

    logic [IW-1:0]   start_w;
    logic [IW:0]     idx;
    logic [IW-1:0]   sel;
    logic [PC_W-1:0] cur;
    logic [PC_W-1:0] nxt;
    logic            live;
    logic            redirect;

    assign start_w = pc_i[IW+1:2];

    always_comb begin
        cur           = pc_i & ~PC_W'(INSN_BYTES - 1);
        live          = 1'b1;
        count_o       = '0;
        last_npc_o    = cur;
        quiesce_hit_o = 1'b0;
        idx           = '0;
        sel           = '0;
        nxt           = '0;
        redirect      = 1'b0;
        for (int k = 0; k < FW; k++) begin
            valid_o[k] = 1'b0;
            inst_o[k]  = '0;
            pc_o[k]    = '0;
            npc_o[k]   = '0;
            idx        = {1'b0, start_w} + (IW+1)'(k);
            if (live && (idx < (IW+1)'(WORDS))) begin
                sel        = idx[IW-1:0];
                redirect   = ctl_i[sel] & taken_i[sel];
                nxt        = redirect ? target_i[sel*PC_W +: PC_W] : cur + PC_W'(INSN_BYTES);
                valid_o[k] = 1'b1;
                inst_o[k]  = line_i[sel*32 +: 32];
                pc_o[k]    = cur;
                npc_o[k]   = nxt;
                count_o    = count_o + CNT_W'(1);
                last_npc_o = nxt;
                cur        = nxt;
                if (redirect || quiesce_i[sel]) begin
                    live          = 1'b0;
                    quiesce_hit_o = quiesce_hit_o | quiesce_i[sel];
                end
            end else begin
                live = 1'b0;
            end
        end
    end

endmodule

// File: rtl/fx_seq_ctr.sv
module fx_seq_ctr #(
    parameter int SEQ_W = 16,
    parameter int ADV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADV_W-1:0] adv_i,
    output logic [SEQ_W-1:0] base_o
);

    always_ff @(posedge clk) begin
        if (rst) base_o <= '0;
        else     base_o <= base_o + SEQ_W'(adv_i);
    end

endmodule

// File: rtl/fx_thread_ctl.sv
module fx_thread_ctl
    import fx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go_i,
    input  logic      fault_i,
    input  logic      quiesce_hit_i,
    input  logic      wake_i,
    output logic      accept_o,
    output th_state_e state_o
);

    assign accept_o = go_i && (state_o == TH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= TH_RUN;
        end else if (state_o != TH_RUN) begin
            if (wake_i) state_o <= TH_RUN;
        end else if (accept_o) begin
            if (fault_i)            state_o <= TH_TRAP;
            else if (quiesce_hit_i) state_o <= TH_QUIESCE;
        end
    end

endmodule

// File: rtl/fx_extractor.sv
module fx_extractor
    import fx_pkg::*;
#(
    parameter int FW         = 4,
    parameter int LINE_BYTES = 64,
    parameter int PC_W       = 32,
    parameter int SEQ_W      = 16,
    parameter logic [31:0] NOP_WORD = 32'h0000_0000,
    localparam int WORDS = LINE_BYTES / INSN_BYTES,
    localparam int CNT_W = $clog2(FW + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fetch_go_i,
    input  logic [PC_W-1:0]       fetch_pc_i,
    input  logic [WORDS*32-1:0]   line_i,
    input  logic [WORDS-1:0]      ctl_i,
    input  logic [WORDS-1:0]      taken_i,
    input  logic [WORDS*PC_W-1:0] target_i,
    input  logic [WORDS-1:0]      quiesce_i,
    input  logic                  xlate_fault_i,
    input  logic                  wake_i,
    output logic [PC_W-1:0]       req_addr_o,
    output logic                  dq_wr_o,
    output logic [CNT_W-1:0]      slot_count_o,
    output logic [FW*32-1:0]      slot_inst_o,
    output logic [FW*PC_W-1:0]    slot_pc_o,
    output logic [FW*PC_W-1:0]    slot_npc_o,
    output logic [FW*SEQ_W-1:0]   slot_seq_o,
    output logic [FW-1:0]         slot_fault_o,
    output logic [PC_W-1:0]       thread_pc_o,
    output logic [PC_W-1:0]       thread_npc_o,
    output logic                  quiesce_pend_o,
    output logic                  trap_pend_o
);

    logic [FW-1:0]    w_valid;
    logic [31:0]      w_inst [FW];
    logic [PC_W-1:0]  w_pc   [FW];
    logic [PC_W-1:0]  w_npc  [FW];
    logic [CNT_W-1:0] w_count;
    logic [PC_W-1:0]  w_last_npc;
    logic             w_qhit;

    logic             accept;
    th_state_e        th_state;
    logic [SEQ_W-1:0] seq_base;
    logic [CNT_W-1:0] seq_adv;
    logic [PC_W-1:0]  pc_aligned;

    logic [31:0]      r_inst [FW];
    logic [PC_W-1:0]  r_pc   [FW];
    logic [PC_W-1:0]  r_npc  [FW];
    logic [SEQ_W-1:0] r_seq  [FW];
    logic [FW-1:0]    r_fault;

    assign req_addr_o = fetch_pc_i & ~PC_W'(LINE_BYTES - 1);
    assign pc_aligned = fetch_pc_i & ~PC_W'(INSN_BYTES - 1);

    fx_slot_walk #(.FW(FW), .WORDS(WORDS), .PC_W(PC_W)) i_walk (
        .pc_i         (fetch_pc_i),
        .line_i       (line_i),
        .ctl_i        (ctl_i),
        .taken_i      (taken_i),
        .target_i     (target_i),
        .quiesce_i    (quiesce_i),
        .valid_o      (w_valid),
        .inst_o       (w_inst),
        .pc_o         (w_pc),
        .npc_o        (w_npc),
        .count_o      (w_count),
        .last_npc_o   (w_last_npc),
        .quiesce_hit_o(w_qhit)
    );

    fx_thread_ctl i_ctl (
        .clk          (clk),
        .rst          (rst),
        .go_i         (fetch_go_i),
        .fault_i      (xlate_fault_i),
        .quiesce_hit_i(w_qhit),
        .wake_i       (wake_i),
        .accept_o     (accept),
        .state_o      (th_state)
    );

    assign seq_adv = !accept ? '0 : (xlate_fault_i ? CNT_W'(1) : w_count);

    fx_seq_ctr #(.SEQ_W(SEQ_W), .ADV_W(CNT_W)) i_seq (
        .clk   (clk),
        .rst   (rst),
        .adv_i (seq_adv),
        .base_o(seq_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_wr_o      <= 1'b0;
            slot_count_o <= '0;
            thread_pc_o  <= '0;
            thread_npc_o <= '0;
            r_fault      <= '0;
            for (int k = 0; k < FW; k++) begin
                r_inst[k] <= '0;
                r_pc[k]   <= '0;
                r_npc[k]  <= '0;
                r_seq[k]  <= '0;
            end
        end else begin
            dq_wr_o      <= 1'b0;
            slot_count_o <= '0;
            r_fault      <= '0;
            for (int k = 0; k < FW; k++) begin
                r_inst[k] <= '0;
                r_pc[k]   <= '0;
                r_npc[k]  <= '0;
                r_seq[k]  <= '0;
            end
            if (accept && xlate_fault_i) begin
                dq_wr_o      <= 1'b1;
                slot_count_o <= CNT_W'(1);
                r_fault[0]   <= 1'b1;
                r_inst[0]    <= NOP_WORD;
                r_pc[0]      <= pc_aligned;
                r_npc[0]     <= pc_aligned + PC_W'(INSN_BYTES);
                r_seq[0]     <= seq_base;
                thread_pc_o  <= pc_aligned;
                thread_npc_o <= pc_aligned + PC_W'(INSN_BYTES);
            end else if (accept) begin
                dq_wr_o      <= (w_count != '0);
                slot_count_o <= w_count;
                thread_pc_o  <= w_last_npc;
                thread_npc_o <= w_last_npc + PC_W'(INSN_BYTES);
                for (int k = 0; k < FW; k++) begin
                    if (w_valid[k]) begin
                        r_inst[k] <= w_inst[k];
                        r_pc[k]   <= w_pc[k];
                        r_npc[k]  <= w_npc[k];
                        r_seq[k]  <= seq_base + SEQ_W'(k);
                    end
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < FW; g++) begin : g_flat
            assign slot_inst_o[g*32 +: 32]      = r_inst[g];
            assign slot_pc_o[g*PC_W +: PC_W]    = r_pc[g];
            assign slot_npc_o[g*PC_W +: PC_W]   = r_npc[g];
            assign slot_seq_o[g*SEQ_W +: SEQ_W] = r_seq[g];
        end
    endgenerate

    assign slot_fault_o   = r_fault;
    assign quiesce_pend_o = (th_state == TH_QUIESCE);
    assign trap_pend_o    = (th_state == TH_TRAP);

endmodule

// File: rtl/fx_extractor_chk.sv
module fx_extractor_chk #(
    parameter int FW    = 4,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                dq_wr_o,
    input logic [CNT_W-1:0]    slot_count_o,
    input logic [FW*PC_W-1:0]  slot_pc_o,
    input logic [FW*PC_W-1:0]  slot_npc_o,
    input logic [FW*SEQ_W-1:0] slot_seq_o,
    input logic [FW-1:0]       slot_fault_o,
    input logic [PC_W-1:0]     thread_pc_o,
    input logic [PC_W-1:0]     thread_npc_o,
    input logic                quiesce_pend_o,
    input logic                trap_pend_o
);

    a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
        slot_count_o <= CNT_W'(FW));

    a_r11_strobe: assert property (@(posedge clk) disable iff (rst)
        dq_wr_o == (slot_count_o != '0));

    a_r8_npc_follows: assert property (@(posedge clk) disable iff (rst)
        dq_wr_o |-> thread_npc_o == thread_pc_o + PC_W'(4));

    a_r9_fault_single: assert property (@(posedge clk) disable iff (rst)
        slot_fault_o[0] |-> (slot_count_o == CNT_W'(1)) && trap_pend_o);

    a_r10_pend_excl: assert property (@(posedge clk) disable iff (rst)
        !(quiesce_pend_o && trap_pend_o));

    a_r10_pend_silent: assert property (@(posedge clk) disable iff (rst)
        $past(quiesce_pend_o || trap_pend_o) |-> !dq_wr_o);

    generate
        if (FW >= 2) begin : g_pair
            a_r3_chain: assert property (@(posedge clk) disable iff (rst)
                (slot_count_o >= CNT_W'(2)) |-> slot_pc_o[PC_W +: PC_W] == slot_npc_o[0 +: PC_W]);
            a_r7_seq_step: assert property (@(posedge clk) disable iff (rst)
                (slot_count_o >= CNT_W'(2)) |->
                    slot_seq_o[SEQ_W +: SEQ_W] == slot_seq_o[0 +: SEQ_W] + SEQ_W'(1));
        end
    endgenerate

endmodule

bind fx_extractor fx_extractor_chk #(
    .FW(FW), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) i_fx_chk (
    .clk           (clk),
    .rst           (rst),
    .dq_wr_o       (dq_wr_o),
    .slot_count_o  (slot_count_o),
    .slot_pc_o     (slot_pc_o),
    .slot_npc_o    (slot_npc_o),
    .slot_seq_o    (slot_seq_o),
    .slot_fault_o  (slot_fault_o),
    .thread_pc_o   (thread_pc_o),
    .thread_npc_o  (thread_npc_o),
    .quiesce_pend_o(quiesce_pend_o),
    .trap_pend_o   (trap_pend_o)
);

// File: tb/test_fx_extractor.sv
`timescale 1ns/1ps
module test_fx_extractor;

    localparam int FW = 4;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0;
    logic [31:0]   pc = '0;
    logic [511:0]  line = '0;
    logic [15:0]   ctl = '0, tk = '0, qu = '0;
    logic [511:0]  tgt = '0;
    logic          fault = 1'b0;
    logic          wake = 1'b0;

    logic [31:0]   req_addr;
    logic          dq_wr;
    logic [2:0]    cnt;
    logic [127:0]  s_inst, s_pc, s_npc;
    logic [63:0]   s_seq;
    logic [3:0]    s_fault;
    logic [31:0]   t_pc, t_npc;
    logic          q_pend, t_pend;

    int n_chk = 0, n_bad = 0;
    logic [15:0] e_seq = '0;

    always #2 clk = ~clk;

    fx_extractor i_fx_extractor (
        .clk(clk), .rst(rst), .fetch_go_i(go), .fetch_pc_i(pc), .line_i(line),
        .ctl_i(ctl), .taken_i(tk), .target_i(tgt), .quiesce_i(qu),
        .xlate_fault_i(fault), .wake_i(wake), .req_addr_o(req_addr),
        .dq_wr_o(dq_wr), .slot_count_o(cnt), .slot_inst_o(s_inst),
        .slot_pc_o(s_pc), .slot_npc_o(s_npc), .slot_seq_o(s_seq),
        .slot_fault_o(s_fault), .thread_pc_o(t_pc), .thread_npc_o(t_npc),
        .quiesce_pend_o(q_pend), .trap_pend_o(t_pend)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // one fetch with arithmetic expectation
    task automatic run_vec(input logic [31:0] fpc, input bit flt);
        logic [31:0] ei [FW];
        logic [31:0] ep [FW];
        logic [31:0] en [FW];
        logic [31:0] cur, nx, last, hold_pc;
        int n, st;
        bit stop, qh, redir;
        for (int k = 0; k < FW; k++) begin ei[k] = 0; ep[k] = 0; en[k] = 0; end
        cur = fpc & ~32'd3; last = cur; n = 0; st = fpc[5:2]; stop = 0; qh = 0;
        if (flt) begin
            n = 1; ep[0] = cur; en[0] = cur + 4; last = cur;
        end else begin
            for (int k = 0; k < FW; k++) begin
                if (!stop && st + k < W) begin
                    redir = ctl[st+k] & tk[st+k];
                    nx = redir ? tgt[(st+k)*32 +: 32] : cur + 4;
                    ei[k] = line[(st+k)*32 +: 32]; ep[k] = cur; en[k] = nx;
                    n++; cur = nx; last = nx;
                    if (redir || qu[st+k]) begin stop = 1; qh = qu[st+k]; end
                end else stop = 1;
            end
        end
        @(negedge clk);
        pc = fpc; fault = flt; go = 1'b1;
        #1;
        chk(req_addr == (fpc & 32'hFFFF_FFC0), "R1", req_addr, fpc & 32'hFFFF_FFC0);
        @(negedge clk);
        go = 1'b0;
        chk(cnt == 3'(n), "R4/R5/R6 count", cnt, n);
        chk(dq_wr == (n != 0), "R11 strobe", dq_wr, n != 0);
        for (int k = 0; k < FW; k++) begin
            chk(s_inst[k*32 +: 32] == ei[k], "R2 inst", s_inst[k*32 +: 32], ei[k]);
            chk(s_pc[k*32 +: 32] == ep[k], "R2/R3 pc", s_pc[k*32 +: 32], ep[k]);
            chk(s_npc[k*32 +: 32] == en[k], "R3/R5 npc", s_npc[k*32 +: 32], en[k]);
            chk(s_seq[k*16 +: 16] == (k < n ? e_seq + 16'(k) : 16'h0), "R7 seq",
                s_seq[k*16 +: 16], (k < n ? e_seq + 16'(k) : 16'h0));
            chk(s_fault[k] == (flt && k == 0), "R9 fault flag", s_fault[k], flt && k == 0);
        end
        e_seq = e_seq + 16'(n);
        chk(t_pc == last, "R8 thread pc", t_pc, last);
        chk(t_npc == last + 4, "R8 thread npc", t_npc, last + 4);
        chk(q_pend == qh && t_pend == flt, "R6/R9 pending", {q_pend, t_pend}, {qh, flt});
        if (qh || flt) begin
            hold_pc = t_pc;
            @(negedge clk); go = 1'b1; fault = 1'b0;
            @(negedge clk); go = 1'b0;
            chk(cnt == 0 && !dq_wr, "R10 ignored go", cnt, 0);
            chk(t_pc == hold_pc, "R10 pc held", t_pc, hold_pc);
            wake = 1'b1;
            @(negedge clk); wake = 1'b0;
            chk(!q_pend && !t_pend, "R10 wake", {q_pend, t_pend}, 0);
        end
    endtask

    initial begin : main
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cnt == 0 && !dq_wr && t_pc == 0 && t_npc == 0 && !q_pend && !t_pend &&
            s_inst == 0 && s_seq == 0, "R12 reset", {cnt, dq_wr, t_pc}, 0);
        rst = 1'b0;
        for (int w = 0; w < W; w++) begin
            line[w*32 +: 32] = 32'hA500_0000 + 32'(w) * 32'h0001_0203;
            tgt[w*32 +: 32]  = 32'h0800_0000 + 32'(w) * 32'h0000_0440 + 32'(w);
        end
        for (int p = 0; p < 35; p++) begin
            for (int off = 0; off < 64; off++) begin
                ctl = '0; tk = '0; qu = '0;
                if (p == 0) tk = '1;
                else if (p <= 16) begin ctl[p-1] = 1'b1; tk[p-1] = 1'b1; end
                else if (p <= 32) qu[p-17] = 1'b1;
                else if (p == 33) ctl = '1;
                run_vec(32'h0040_0000 + 32'(p) * 32'h0000_1040 + 32'(off), p == 34);
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule